// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two up-counters, timer 0 and timer 1, each kept as a low byte and a high byte. Each counter has its own 4-bit configuration nibble. The nibble holds a gate-enable bit, a source-select bit and a 2-bit counting mode. A shared control register holds one run bit and one overflow flag per timer.

A counter counts one of two sources: machine cycles, marked by the `mc_tick` enable pulse from an external prescaler, or falling events on its external event pin. The gate-enable bit makes counting depend on the level of a companion gate pin. The four modes are:

- a 13-bit count, made of a 5-bit prescaler stage feeding an 8-bit stage;
- a plain 16-bit count;
- an 8-bit count that reloads itself from the high byte;
- a split mode for timer 0.

In split mode, timer 0's high byte becomes a third counter. It borrows timer 1's run bit and timer 1's overflow flag.

Software reaches all registers through a simple write port and a combinational read port. An interrupt controller outside the block reads the two flags and clears them with acknowledge pulses. Timer 1's overflow is also sent out as a single-cycle tick, for use as a baud-rate clock.

Top module: `cyc_timer_pair`

## Requirements
- R1: After reset, every register reads 0 and both `ovf_flag` bits and `baud_tick` are 0.
- R2: The register addresses are: 0 mode, 1 control, 2 timer-0 low, 3 timer-0 high, 4 timer-1 low, 5 timer-1 high. The mode register holds timer 0 in bits 3:0 and timer 1 in bits 7:4. Within each nibble, bit 3 is gate-enable, bit 2 is source select (1 = event pin) and bits 1:0 are the mode. The control register holds run0 in bit 0, run1 in bit 1, flag0 in bit 2 and flag1 in bit 3. A write to a count register stores the written value even when a count occurs in the same cycle.
- R3: In mode 01 the 16-bit value {high,low} increments by one per count and wraps from FFFF to 0000. The wrap sets that timer's flag.
- R4: In mode 00 the low 5 bits of the low byte act as a prescaler. A carry out of those 5 bits increments the high byte. Low-byte bits 7:5 keep their value. The flag is set when the 13-bit value wraps from 1FFF to 0000.
- R5: In mode 10 the low byte increments. A count at FF reloads the low byte from the high byte and sets the flag. The high byte is unchanged.
- R6: A timer counts only when its run bit is 1 and its gate-enable bit is 0 or its gate pin is 1.
- R7: With source select 1, a count occurs on an `mc_tick` cycle where the pin sample taken at the previous `mc_tick` was 1 and the current pin value is 0. Pin changes between `mc_tick` pulses produce no count.
- R8: With timer 0 in mode 11, timer 0's low byte is an 8-bit counter under timer 0's own controls, and its wrap sets flag0. Timer 0's high byte counts every `mc_tick` while run1 is 1, and its wrap from FF sets flag1.
- R9: While timer 0 is in mode 11, timer 1 in modes 00–10 counts regardless of run1 (its gate still applies). Its overflow does not set flag1 but still produces `baud_tick`.
- R10: Timer 1 in mode 11 holds its count and produces no `baud_tick`.
- R11: An `ovf_ack` bit clears the matching flag, but an overflow in the same cycle keeps that flag set. A control-register write loads both flags from bits 3:2 and takes priority over both.
- R12: `baud_tick` is high for exactly the one clock cycle that follows the clock edge at which timer 1 overflows. Timer 0 never drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle enable from the prescaler |
| gate_pin | input | 2 | Per-timer gate level (bit 0 timer 0) |
| evt_pin | input | 2 | Per-timer external event pin |
| ovf_ack | input | 2 | Per-timer flag clear pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | BYTE_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | BYTE_W | Register read data (combinational) |
| ovf_flag | output | 2 | Overflow flags (bit 0 timer 0) |
| baud_tick | output | 1 | One-cycle timer-1 overflow pulse |

## Verification
A wrong count or mode decode shows up on the read port after the very next `mc_tick`. The bench therefore walks each mode through its wrap point one machine cycle at a time and compares every intermediate value with arithmetic done in the bench. Wrong flag routing in split mode shows as a flag that appears, or fails to appear, on the cycle after the responsible wrap. A wrong `baud_tick` shows as a pulse that is missing, is on the wrong step, or is still high one cycle later.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

  typedef enum logic [1:0] {
    CM_PRE13   = 2'b00,
    CM_FULL16  = 2'b01,
    CM_RELOAD8 = 2'b10,
    CM_SPLIT   = 2'b11
  } cnt_mode_e;

  // Nibble layout: gate, source select, mode[1:0]
  typedef struct packed {
    logic      gate;
    logic      ext;
    cnt_mode_e mode;
  } tmr_cfg_t;

  localparam int unsigned RA_W = 3;
  localparam logic [RA_W-1:0] RA_MODE = 3'd0;
  localparam logic [RA_W-1:0] RA_CTRL = 3'd1;
  localparam logic [RA_W-1:0] RA_T0LO = 3'd2;
  localparam logic [RA_W-1:0] RA_T0HI = 3'd3;
  localparam logic [RA_W-1:0] RA_T1LO = 3'd4;
  localparam logic [RA_W-1:0] RA_T1HI = 3'd5;

endpackage

// File: rtl/cyc_edge_sampler.sv
module cyc_edge_sampler #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_en,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] fall_o
);

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic smp_q, smp_d;

    always_comb begin
      smp_d = smp_q;
      if (smp_en) smp_d = pin_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smp_q <= 1'b0;
      else        smp_q <= smp_d;
    end

    assign fall_o[g] = smp_en & smp_q & ~pin_i[g];
  end

endmodule

// File: rtl/cyc_count_core.sv
module cyc_count_core
  import cyc_timer_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned PRE_W    = 5,
  parameter int unsigned SPLIT_OK = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cnt_mode_e         mode_i,
  input  logic              inc_i,
  input  logic              inc_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_o,
  output logic              ovf_hi_o
);

  localparam int unsigned CNT_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] B_ONES = '1;
  localparam logic [PRE_W-1:0]  P_ONES = '1;

  logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic              ovf_d, ovf_hi_d;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_d    = 1'b0;
    ovf_hi_d = 1'b0;
    case (mode_i)
      CM_PRE13: begin
        if (inc_i) begin
          if (lo_q[PRE_W-1:0] == P_ONES) begin
            lo_d[PRE_W-1:0] = '0;
            hi_d            = hi_q + 1'b1;
            ovf_d           = (hi_q == B_ONES);
          end else begin
            lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
          end
        end
      end
      CM_FULL16: begin
        if (inc_i) begin
          {hi_d, lo_d} = {hi_q, lo_q} + CNT_W'(1);
          ovf_d        = (hi_q == B_ONES) && (lo_q == B_ONES);
        end
      end
      CM_RELOAD8: begin
        if (inc_i) begin
          if (lo_q == B_ONES) begin
            lo_d  = hi_q;
            ovf_d = 1'b1;
          end else begin
            lo_d = lo_q + 1'b1;
          end
        end
      end
      CM_SPLIT: begin
        if (SPLIT_OK != 0) begin
          if (inc_i) begin
            lo_d  = lo_q + 1'b1;
            ovf_d = (lo_q == B_ONES);
          end
          if (inc_hi_i) begin
            hi_d     = hi_q + 1'b1;
            ovf_hi_d = (hi_q == B_ONES);
          end
        end
      end
    endcase
    if (wr_lo_i) lo_d = wdata_i;
    if (wr_hi_i) hi_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o     = lo_q;
  assign hi_o     = hi_q;
  assign ovf_o    = ovf_d;
  assign ovf_hi_o = ovf_hi_d;

  // R6: with no count request and no write the count stays put
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !inc_hi_i && !wr_lo_i && !wr_hi_i) |=> ($stable(lo_q) && $stable(hi_q)));

  // R5: low byte takes the old high byte when it wraps in reload mode
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == CM_RELOAD8 && inc_i && lo_q == B_ONES && !wr_lo_i) |=> (lo_q == $past(hi_q)));

  if (SPLIT_OK == 0) begin : g_freeze_chk
    // R10: a timer without split support freezes in mode 11
    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == CM_SPLIT && !wr_lo_i && !wr_hi_i) |=> ($stable(lo_q) && $stable(hi_q)));
  end

endmodule

// File: rtl/cyc_timer_ctrl.sv
module cyc_timer_ctrl #(
  parameter int unsigned MODE_W = 8,
  parameter int unsigned NTMR   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode_i,
  input  logic              wr_ctrl_i,
  input  logic [MODE_W-1:0] mode_wd_i,
  input  logic [NTMR-1:0]   run_wd_i,
  input  logic [NTMR-1:0]   flag_wd_i,
  input  logic [NTMR-1:0]   set_i,
  input  logic [NTMR-1:0]   ack_i,
  input  logic              tick_src_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [NTMR-1:0]   run_o,
  output logic [NTMR-1:0]   flag_o,
  output logic              tick_o
);

  logic [MODE_W-1:0] mode_q, mode_d;
  logic [NTMR-1:0]   run_q, run_d, flag_q, flag_d;
  logic              tick_q;

  always_comb begin
    mode_d = mode_q;
    run_d  = run_q;
    flag_d = (flag_q & ~ack_i) | set_i;
    if (wr_mode_i) mode_d = mode_wd_i;
    if (wr_ctrl_i) begin
      run_d  = run_wd_i;
      flag_d = flag_wd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
      tick_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      flag_q <= flag_d;
      tick_q <= tick_src_i;
    end
  end

  assign mode_o = mode_q;
  assign run_o  = run_q;
  assign flag_o = flag_q;
  assign tick_o = tick_q;

  // R3: an overflow event always leaves its flag set unless software writes it
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i && !wr_ctrl_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  // R11: an acknowledge without a competing overflow clears the flag
  p_ack_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_i & ~set_i) && !wr_ctrl_i) |=> ((flag_q & $past(ack_i & ~set_i)) == '0));

endmodule

// File: rtl/cyc_timer_pair.sv
module cyc_timer_pair
  import cyc_timer_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic [1:0]        gate_pin,
  input  logic [1:0]        evt_pin,
  input  logic [1:0]        ovf_ack,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [1:0]        ovf_flag,
  output logic              baud_tick
);

  localparam int unsigned NTMR   = 2;
  localparam int unsigned CFG_W  = $bits(tmr_cfg_t);
  localparam int unsigned MODE_W = NTMR * CFG_W;
  localparam int unsigned PAD_W  = BYTE_W - 2 * NTMR;

  logic [MODE_W-1:0] mode_q;
  logic [NTMR-1:0]   run_q, flag_q, fall;
  logic [NTMR-1:0]   run_eff, inc, inc_hi, wr_lo, wr_hi, ovf, hi_ovf, set;
  logic              wr_mode, wr_ctrl, split, tick_q;
  tmr_cfg_t          cfg   [NTMR];
  logic [BYTE_W-1:0] lo_v  [NTMR];
  logic [BYTE_W-1:0] hi_v  [NTMR];

  assign wr_mode = wr_en && (wr_addr == RA_MODE);
  assign wr_ctrl = wr_en && (wr_addr == RA_CTRL);

  cyc_edge_sampler #(.N(NTMR)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_en (mc_tick),
    .pin_i  (evt_pin),
    .fall_o (fall)
  );

  // Split mode of timer 0 hands run1 to its high byte; timer 1 then runs freely
  assign split      = (cfg[0].mode == CM_SPLIT);
  assign run_eff[0] = run_q[0];
  assign run_eff[1] = run_q[1] | split;
  assign inc_hi[0]  = split & run_q[1] & mc_tick;
  assign inc_hi[1]  = 1'b0;

  for (genvar i = 0; i < NTMR; i++) begin : g_tmr
    logic en, src;
    assign cfg[i]   = tmr_cfg_t'(mode_q[i*CFG_W +: CFG_W]);
    assign en       = run_eff[i] & (~cfg[i].gate | gate_pin[i]);
    assign src      = cfg[i].ext ? fall[i] : mc_tick;
    assign inc[i]   = en & src;
    assign wr_lo[i] = wr_en && (wr_addr == RA_W'(RA_T0LO + 2 * i));
    assign wr_hi[i] = wr_en && (wr_addr == RA_W'(RA_T0HI + 2 * i));

    cyc_count_core #(
      .BYTE_W   (BYTE_W),
      .PRE_W    (PRE_W),
      .SPLIT_OK ((i == 0) ? 1 : 0)
    ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (cfg[i].mode),
      .inc_i    (inc[i]),
      .inc_hi_i (inc_hi[i]),
      .wr_lo_i  (wr_lo[i]),
      .wr_hi_i  (wr_hi[i]),
      .wdata_i  (wr_data),
      .lo_o     (lo_v[i]),
      .hi_o     (hi_v[i]),
      .ovf_o    (ovf[i]),
      .ovf_hi_o (hi_ovf[i])
    );
  end

  // Flag 1 source moves to the split high byte (timer 1 core never raises hi_ovf)
  assign set[0] = ovf[0];
  assign set[1] = split ? (|hi_ovf) : ovf[1];

  cyc_timer_ctrl #(.MODE_W(MODE_W), .NTMR(NTMR)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_mode_i  (wr_mode),
    .wr_ctrl_i  (wr_ctrl),
    .mode_wd_i  (wr_data[MODE_W-1:0]),
    .run_wd_i   (wr_data[NTMR-1:0]),
    .flag_wd_i  (wr_data[2*NTMR-1:NTMR]),
    .set_i      (set),
    .ack_i      (ovf_ack),
    .tick_src_i (ovf[1]),
    .mode_o     (mode_q),
    .run_o      (run_q),
    .flag_o     (flag_q),
    .tick_o     (tick_q)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_MODE: rd_data = BYTE_W'(mode_q);
      RA_CTRL: rd_data = {{PAD_W{1'b0}}, flag_q, run_q};
      RA_T0LO: rd_data = lo_v[0];
      RA_T0HI: rd_data = hi_v[0];
      RA_T1LO: rd_data = lo_v[1];
      RA_T1HI: rd_data = hi_v[1];
      default: rd_data = '0;
    endcase
  end

  assign ovf_flag  = flag_q;
  assign baud_tick = tick_q;

  // R9: in split mode a timer-1 wrap alone never raises flag1
  p_split_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !hi_ovf[0] && !wr_ctrl && !flag_q[1]) |=> !ovf_flag[1]);

  // R12: every timer-1 overflow is followed by the tick
  p_tick_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (inc[1] && cfg[1].mode == CM_FULL16 && lo_v[1] == '1 && hi_v[1] == '1 && !wr_lo[1] && !wr_hi[1])
    |=> baud_tick);

endmodule

// File: tb/cyc_timer_pair_bench.sv
`timescale 1ns/1ps
module cyc_timer_pair_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mc_tick;
  logic [1:0] gate_pin, evt_pin, ovf_ack;
  logic       wr_en;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [1:0] ovf_flag;
  logic       baud_tick;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  cyc_timer_pair u_cyc_timer_pair (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .gate_pin(gate_pin),
    .evt_pin(evt_pin), .ovf_ack(ovf_ack), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ovf_flag(ovf_flag), .baud_tick(baud_tick)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic rd16(input logic [2:0] lo_a, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo_a, l);
    rd(lo_a + 3'd1, h);
    v = {h, l};
  endtask

  task automatic tick1();
    @(negedge clk); mc_tick = 1'b1;
    @(negedge clk); mc_tick = 1'b0;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    logic [7:0]  v8;
    logic [15:0] v16, e16;
    logic [12:0] e13;
    logic [7:0]  l;
    logic        fl, ov, prev;
    int          cnt;
    logic [15:0] pat;

    rst_n = 1'b0; mc_tick = 0; gate_pin = 0; evt_pin = 0; ovf_ack = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v8);
      chk($sformatf("R1 reg %0d", a), v8, 0);
    end
    chk("R1 flags", ovf_flag, 0);
    chk("R1 baud_tick", baud_tick, 0);

    // R3 16-bit wrap
    wr(3'd0, 8'h01); wr(3'd2, 8'hF0); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    for (int k = 1; k <= 40; k++) begin
      tick1();
      rd16(3'd2, v16);
      e16 = 16'hFFF0 + 16'(k);
      chk("R3 count16", v16, e16);
      chk("R3 flag0", ovf_flag[0], (k >= 16));
      chk("R12 no tick from timer 0", baud_tick, 0);
    end

    // R4 13-bit with prescaler
    wr(3'd0, 8'h00); wr(3'd2, 8'hFA); wr(3'd3, 8'hFF); wr(3'd1, 8'h01);
    for (int k = 1; k <= 12; k++) begin
      tick1();
      e13 = 13'h1FFA + 13'(k);
      rd16(3'd2, v16);
      chk("R4 low byte", v16[7:0], {3'b111, e13[4:0]});
      chk("R4 high byte", v16[15:8], e13[12:5]);
      chk("R4 flag0", ovf_flag[0], (k >= 6));
    end

    // R5 auto reload
    wr(3'd0, 8'h02); wr(3'd3, 8'hFB); wr(3'd2, 8'hFD); wr(3'd1, 8'h01);
    l = 8'hFD; fl = 0;
    for (int k = 1; k <= 20; k++) begin
      tick1();
      if (l == 8'hFF) begin l = 8'hFB; fl = 1; end else l = l + 1;
      rd16(3'd2, v16);
      chk("R5 reload low", v16[7:0], l);
      chk("R5 high kept", v16[15:8], 8'hFB);
      chk("R5 flag0", ovf_flag[0], fl);
    end
    // R11 acknowledge clears
    @(negedge clk); ovf_ack = 2'b01;
    @(negedge clk); ovf_ack = 2'b00;
    chk("R11 ack clears flag0", ovf_flag[0], 0);

    // R6 gating and run bit
    wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
    gate_pin = 2'b00;
    repeat (5) tick1();
    rd16(3'd2, v16); chk("R6 gate low blocks", v16, 0);
    gate_pin = 2'b01;
    repeat (5) tick1();
    rd16(3'd2, v16); chk("R6 gate high counts", v16, 5);
    wr(3'd1, 8'h00);
    repeat (3) tick1();
    rd16(3'd2, v16); chk("R6 run off holds", v16, 5);
    gate_pin = 2'b00;

    // R7 external events
    wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
    pat = 16'b1011_0010_1101_0110; prev = 0; cnt = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); evt_pin[0] = pat[i];
      tick1();
      if (prev && !pat[i]) cnt++;
      prev = pat[i];
      rd16(3'd2, v16);
      chk("R7 event count", v16, 16'(cnt));
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); evt_pin[0] = ~prev;
      @(negedge clk); evt_pin[0] = prev;
    end
    @(negedge clk);
    rd16(3'd2, v16); chk("R7 no count without mc_tick", v16, 16'(cnt));

    // R2 write beats same-cycle count; register map
    wr(3'd0, 8'h01);
    @(negedge clk); mc_tick = 1; wr_en = 1; wr_addr = 3'd2; wr_data = 8'h55;
    @(negedge clk); mc_tick = 0; wr_en = 0;
    rd(3'd2, v8); chk("R2 write wins", v8, 8'h55);
    rd(3'd0, v8); chk("R2 mode readback", v8, 8'h01);
    rd(3'd1, v8); chk("R2 ctrl readback", v8, 8'h01);

    // R8 / R9 split mode, run1 off
    wr(3'd0, 8'h13); wr(3'd2, 8'hFE); wr(3'd3, 8'hFD);
    wr(3'd4, 8'hFE); wr(3'd5, 8'hFF); wr(3'd1, 8'h01);
    for (int k = 1; k <= 3; k++) begin
      tick1();
      ov = (k == 2);
      chk("R12 tick while split", baud_tick, ov);
      rd(3'd2, v8); chk("R8 split low", v8, 8'(8'hFE + k));
      rd(3'd3, v8); chk("R8 split high idle", v8, 8'hFD);
      rd16(3'd4, v16); chk("R9 timer1 free run", v16, 16'(16'hFFFE + k));
      chk("R8 flag0", ovf_flag[0], (k >= 2));
      chk("R9 no flag1", ovf_flag[1], 0);
    end
    // run1 on: high byte counts and owns flag1
    wr(3'd1, 8'h03);
    for (int k = 1; k <= 4; k++) begin
      tick1();
      rd(3'd3, v8); chk("R8 split high", v8, 8'(8'hFD + k));
      rd(3'd2, v8); chk("R8 split low cont", v8, 8'(1 + k));
      rd16(3'd4, v16); chk("R9 timer1 cont", v16, 16'(1 + k));
      chk("R8 flag1 from high byte", ovf_flag[1], (k >= 3));
    end

    // R10 timer 1 frozen in mode 11
    wr(3'd0, 8'h31); wr(3'd1, 8'h03);
    for (int k = 1; k <= 5; k++) begin
      tick1();
      chk("R10 no tick", baud_tick, 0);
    end
    rd16(3'd4, v16); chk("R10 timer1 held", v16, 16'h0005);

    // R12 reload mode tick pulses
    wr(3'd0, 8'h20); wr(3'd5, 8'hFC); wr(3'd4, 8'hFE); wr(3'd1, 8'h02);
    l = 8'hFE; fl = 0;
    for (int k = 1; k <= 12; k++) begin
      tick1();
      ov = (l == 8'hFF);
      if (ov) begin l = 8'hFC; fl = 1; end else l = l + 1;
      chk("R12 tick on overflow", baud_tick, ov);
      rd(3'd4, v8); chk("R5 timer1 reload", v8, l);
      chk("R3 flag1 sticky", ovf_flag[1], fl);
      @(negedge clk);
      chk("R12 tick one cycle", baud_tick, 0);
    end
    // R11 overflow beats acknowledge, then ack alone, then control write
    tick1();
    @(negedge clk); mc_tick = 1; ovf_ack = 2'b10;
    @(negedge clk); mc_tick = 0; ovf_ack = 2'b00;
    chk("R11 overflow beats ack", ovf_flag[1], 1);
    @(negedge clk); ovf_ack = 2'b10;
    @(negedge clk); ovf_ack = 2'b00;
    chk("R11 ack clears flag1", ovf_flag[1], 0);
    wr(3'd1, 8'h0C);
    chk("R11 write loads flags", ovf_flag, 2'b11);
    rd(3'd1, v8); chk("R11 ctrl readback", v8, 8'h0C);

    report();
    $finish;
  end

endmodule